// File: doc/BRIEF.md
# Paged Event Buffer Pointer Manager

This block produces the addresses for an event buffer of 32-bit words. The buffer is split into 64 pages of 128 words, and each page holds one event. A front end writes the words of an event one at a time and then closes the event. A host reads the words of the oldest complete event and then releases its page. Each pointer has two fields, a page and a word. A page advance moves the page field forward, wrapping from 63 back to 0, and sets the word field to zero. The result is a FIFO of whole events, and inside each event a FIFO of words.

The block also keeps the length of every closed page, so the reader knows where an event ends. An abort rewinds the open page, and the next event writes over the discarded words. The block raises full and empty status and sets sticky error flags when a close is rejected or a page overruns. The block outputs the write enable and both addresses for an external dual-port RAM, and holds no data itself.

The writer is a two-state machine:
- `W_FILL`: the open page still has free locations.
- `W_TOP`: location 127 has been written.

Writer transitions:
- FILL→TOP when location 127 is written.
- Any state→FILL on an abort or a close.

The reader is a three-state machine:
- `R_EMPTY`: no event is available yet.
- `R_DATA`: words remain in the event.
- `R_DRAINED`: every word of the event has been read.

Reader transitions:
- EMPTY→DATA when an event with at least one word appears.
- EMPTY→DRAINED when an event with zero words appears.
- DATA→DRAINED when the last word is read.
- DATA→EMPTY or DRAINED→EMPTY on a release.

Top module: `evbuf_ptr_mgr`

## Requirements
- R1: Reset (active-low `rst_n`, asynchronous) clears both pointers to zero and clears `full`, `evt_ovf` and `pg_ovf`. After reset `empty` is 1.
- R2: Each pointer is 13 bits: bits [12:7] are the page and bits [6:0] are the word. `wr_we` is high in a cycle where a word write is accepted, and the word is then stored at the address on `wr_ptr`.
- R3: An accepted word write increments the word field of `wr_ptr` by one on the next clock edge.
- R4: An accepted close stores the word count of the open page, increments the page field (wrapping 63→0) and clears the word field.
- R5: `full` is 1 when the write page plus one (modulo 64) equals the read page. A close while full is rejected: the page field is unchanged, the word field is cleared, and the sticky `evt_ovf` flag is set.
- R6: An abort clears the write word field and leaves the page field unchanged. An abort takes priority over a close and a write in the same cycle, and a close takes priority over a write.
- R7: After 128 words have been written in a page, the word field stays at 127. Any further write drives `wr_we` low and sets the sticky `pg_ovf` flag.
- R8: `evt_avail` is 1 and `empty` is 0 exactly when the read and write page fields differ. `rd_len` gives the recorded word count of the page at the read pointer.
- R9: While words remain, `rd_word` increments the read word field. `rd_done` becomes 1 once the number of words read equals `rd_len`. After that, `rd_word` leaves `rd_ptr` unchanged.
- R10: `rd_release` with an event available advances the read page (wrapping) and clears the read word field. With no event available, `rd_release` leaves `rd_ptr` unchanged.
- R11: `rd_valid` and `rd_done` update one clock after an event becomes available or after a release. A page holding zero words shows `rd_done`=1 and `rd_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_word | input | 1 | Store one word at the write pointer |
| wr_close | input | 1 | Close the open event and move to the next page |
| wr_abort | input | 1 | Discard the open event |
| rd_word | input | 1 | Advance past the word at the read pointer |
| rd_release | input | 1 | Release the read page |
| wr_ptr | output | 13 | Write address: page and word |
| wr_we | output | 1 | RAM write enable for an accepted word |
| rd_ptr | output | 13 | Read address: page and word |
| rd_len | output | 8 | Word count of the page being read |
| rd_valid | output | 1 | A word is available at `rd_ptr` |
| rd_done | output | 1 | All words of the current event have been read |
| full | output | 1 | The next close would be rejected |
| empty | output | 1 | No closed event waits |
| evt_avail | output | 1 | A closed event waits |
| evt_ovf | output | 1 | Sticky: a close was rejected |
| pg_ovf | output | 1 | Sticky: a write past location 127 was attempted |

## Verification
A writer stuck in the wrong state shows up within one clock as a `wr_we` that follows the wrong rule near location 127, or as a word field that moves when it should hold. A wrong page field or a wrong length record is not visible until the reader reaches that page. At that point `rd_len`, `rd_done` or the `full`/`empty` pair disagrees with the count expected from the events already closed. The bench therefore walks events through the complete page ring and reads some of them back.

// File: rtl/evbuf_pkg.sv
package evbuf_pkg;
    typedef enum logic [0:0] {
        W_FILL = 1'b0,
        W_TOP  = 1'b1
    } wr_state_t;

    typedef enum logic [1:0] {
        R_EMPTY   = 2'd0,
        R_DATA    = 2'd1,
        R_DRAINED = 2'd2
    } rd_state_t;
endpackage

// File: rtl/evbuf_len_table.sv
module evbuf_len_table #(
    parameter int PAGE_W = 6,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PAGE_W-1:0] waddr,
    input  logic [LEN_W-1:0]  wdata,
    input  logic [PAGE_W-1:0] raddr,
    output logic [LEN_W-1:0]  rdata
);
    localparam int PAGES = 1 << PAGE_W;

    logic [LEN_W-1:0] len_q [PAGES];

    // One register per page; each slot is rewritten only when its page is closed.
    for (genvar g = 0; g < PAGES; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                len_q[g] <= '0;
            else if (we && (waddr == PAGE_W'(g)))
                len_q[g] <= wdata;
        end
    end

    assign rdata = len_q[raddr];
endmodule

// File: rtl/evbuf_wr_fsm.sv
module evbuf_wr_fsm
    import evbuf_pkg::*;
#(
    parameter int PAGE_W = 6,
    parameter int WORD_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_word,
    input  logic              wr_close,
    input  logic              wr_abort,
    input  logic              full,
    output logic [PAGE_W-1:0] page,
    output logic [WORD_W-1:0] word,
    output logic              we,
    output logic              len_we,
    output logic [WORD_W:0]   len_wdata,
    output logic              evt_ovf,
    output logic              pg_ovf
);
    localparam logic [WORD_W-1:0] WORD_MAX = {WORD_W{1'b1}};
    localparam logic [WORD_W:0]   PAGE_CAP = {1'b1, {WORD_W{1'b0}}};

    wr_state_t         st_q, st_d;
    logic [PAGE_W-1:0] page_d;
    logic [WORD_W-1:0] word_d;
    logic              eo_set, po_set;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= W_FILL;
        else
            st_q <= st_d;
    end

    // Next state and outputs. Priority: abort, then close, then word write.
    always_comb begin
        st_d      = st_q;
        page_d    = page;
        word_d    = word;
        we        = 1'b0;
        len_we    = 1'b0;
        len_wdata = (st_q == W_TOP) ? PAGE_CAP : {1'b0, word};
        eo_set    = 1'b0;
        po_set    = 1'b0;
        if (wr_abort) begin
            word_d = '0;
            st_d   = W_FILL;
        end else if (wr_close) begin
            word_d = '0;
            st_d   = W_FILL;
            if (full) begin
                eo_set = 1'b1;
            end else begin
                len_we = 1'b1;
                page_d = page + 1'b1;
            end
        end else if (wr_word) begin
            unique case (st_q)
                W_FILL: begin
                    we = 1'b1;
                    if (word == WORD_MAX)
                        st_d = W_TOP;
                    else
                        word_d = word + 1'b1;
                end
                W_TOP: begin
                    po_set = 1'b1;
                end
                default: st_d = W_FILL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page    <= '0;
            word    <= '0;
            evt_ovf <= 1'b0;
            pg_ovf  <= 1'b0;
        end else begin
            page    <= page_d;
            word    <= word_d;
            evt_ovf <= evt_ovf | eo_set;
            pg_ovf  <= pg_ovf | po_set;
        end
    end
endmodule

// File: rtl/evbuf_rd_fsm.sv
module evbuf_rd_fsm
    import evbuf_pkg::*;
#(
    parameter int PAGE_W = 6,
    parameter int WORD_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_word,
    input  logic              rd_release,
    input  logic              avail,
    input  logic [WORD_W:0]   len,
    output logic [PAGE_W-1:0] page,
    output logic [WORD_W-1:0] word,
    output logic              valid,
    output logic              done
);
    localparam logic [WORD_W-1:0] WORD_MAX = {WORD_W{1'b1}};

    rd_state_t         st_q, st_d;
    logic [PAGE_W-1:0] page_d;
    logic [WORD_W-1:0] word_d;
    logic [WORD_W:0]   cnt_q, cnt_d, cnt_inc;

    assign cnt_inc = cnt_q + 1'b1;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= R_EMPTY;
        else
            st_q <= st_d;
    end

    // Next state and outputs
    always_comb begin
        st_d   = st_q;
        page_d = page;
        word_d = word;
        cnt_d  = cnt_q;
        unique case (st_q)
            R_EMPTY: begin
                if (avail)
                    st_d = (len == '0) ? R_DRAINED : R_DATA;
            end
            R_DATA: begin
                if (rd_release) begin
                    page_d = page + 1'b1;
                    word_d = '0;
                    cnt_d  = '0;
                    st_d   = R_EMPTY;
                end else if (rd_word) begin
                    cnt_d = cnt_inc;
                    if (word != WORD_MAX)
                        word_d = word + 1'b1;
                    if (cnt_inc == len)
                        st_d = R_DRAINED;
                end
            end
            R_DRAINED: begin
                if (rd_release) begin
                    page_d = page + 1'b1;
                    word_d = '0;
                    cnt_d  = '0;
                    st_d   = R_EMPTY;
                end
            end
            default: st_d = R_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page  <= '0;
            word  <= '0;
            cnt_q <= '0;
        end else begin
            page  <= page_d;
            word  <= word_d;
            cnt_q <= cnt_d;
        end
    end

    assign valid = (st_q == R_DATA);
    assign done  = (st_q == R_DRAINED);
endmodule

// File: rtl/evbuf_ptr_mgr.sv
module evbuf_ptr_mgr #(
    parameter int PAGE_W = 6,
    parameter int WORD_W = 7,
    localparam int PTR_W = PAGE_W + WORD_W,
    localparam int LEN_W = WORD_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_word,
    input  logic             wr_close,
    input  logic             wr_abort,
    input  logic             rd_word,
    input  logic             rd_release,
    output logic [PTR_W-1:0] wr_ptr,
    output logic             wr_we,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [LEN_W-1:0] rd_len,
    output logic             rd_valid,
    output logic             rd_done,
    output logic             full,
    output logic             empty,
    output logic             evt_avail,
    output logic             evt_ovf,
    output logic             pg_ovf
);
    logic [PAGE_W-1:0] wpage, rpage, wpage_inc;
    logic [WORD_W-1:0] wword, rword;
    logic              len_we;
    logic [LEN_W-1:0]  len_wdata;

    assign wpage_inc = wpage + 1'b1;
    assign full      = (wpage_inc == rpage);
    assign evt_avail = (wpage != rpage);
    assign empty     = ~evt_avail;
    assign wr_ptr    = {wpage, wword};
    assign rd_ptr    = {rpage, rword};

    evbuf_wr_fsm #(.PAGE_W(PAGE_W), .WORD_W(WORD_W)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_word   (wr_word),
        .wr_close  (wr_close),
        .wr_abort  (wr_abort),
        .full      (full),
        .page      (wpage),
        .word      (wword),
        .we        (wr_we),
        .len_we    (len_we),
        .len_wdata (len_wdata),
        .evt_ovf   (evt_ovf),
        .pg_ovf    (pg_ovf)
    );

    evbuf_len_table #(.PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_len (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (len_we),
        .waddr (wpage),
        .wdata (len_wdata),
        .raddr (rpage),
        .rdata (rd_len)
    );

    evbuf_rd_fsm #(.PAGE_W(PAGE_W), .WORD_W(WORD_W)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_word    (rd_word),
        .rd_release (rd_release),
        .avail      (evt_avail),
        .len        (rd_len),
        .page       (rpage),
        .word       (rword),
        .valid      (rd_valid),
        .done       (rd_done)
    );
endmodule

// File: rtl/evbuf_ptr_chk.sv
module evbuf_ptr_chk #(
    parameter int PAGE_W = 6,
    parameter int WORD_W = 7,
    localparam int PTR_W = PAGE_W + WORD_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_word,
    input logic             wr_close,
    input logic             wr_abort,
    input logic [PTR_W-1:0] wr_ptr,
    input logic             wr_we,
    input logic [PTR_W-1:0] rd_ptr,
    input logic             full,
    input logic             empty,
    input logic             evt_ovf,
    input logic             pg_ovf
);
    localparam logic [WORD_W-1:0] WMAX = {WORD_W{1'b1}};

    logic [PAGE_W-1:0] wp;
    logic [WORD_W-1:0] ww;
    assign wp = wr_ptr[PTR_W-1:WORD_W];
    assign ww = wr_ptr[WORD_W-1:0];

    AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_we |=> ($stable(wp) && ((ww == WORD_W'($past(ww) + 1'b1)) || (ww == WMAX && $past(ww) == WMAX)))); // R3
    AST_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_close && !wr_abort && !full) |=> (wp == PAGE_W'($past(wp) + 1'b1) && ww == '0)); // R4
    AST_FULL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_close && !wr_abort && full) |=> ($stable(wp) && ww == '0 && evt_ovf)); // R5
    AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_abort |=> ($stable(wp) && ww == '0)); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_word && !wr_we && !wr_close && !wr_abort) |=> (pg_ovf && ww == WMAX)); // R7
    AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        empty |=> $stable(rd_ptr)); // R10
endmodule

bind evbuf_ptr_mgr evbuf_ptr_chk #(.PAGE_W(PAGE_W), .WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_word  (wr_word),
    .wr_close (wr_close),
    .wr_abort (wr_abort),
    .wr_ptr   (wr_ptr),
    .wr_we    (wr_we),
    .rd_ptr   (rd_ptr),
    .full     (full),
    .empty    (empty),
    .evt_ovf  (evt_ovf),
    .pg_ovf   (pg_ovf)
);

// File: tb/sim_evbuf_ptr_mgr.sv
module sim_evbuf_ptr_mgr;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_word = 0, wr_close = 0, wr_abort = 0, rd_word = 0, rd_release = 0;
    logic [12:0] wr_ptr, rd_ptr;
    logic [7:0]  rd_len;
    logic wr_we, rd_valid, rd_done, full, empty, evt_avail, evt_ovf, pg_ovf;
    logic last_we;
    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    evbuf_ptr_mgr u0 (
        .clk(clk), .rst_n(rst_n), .wr_word(wr_word), .wr_close(wr_close),
        .wr_abort(wr_abort), .rd_word(rd_word), .rd_release(rd_release),
        .wr_ptr(wr_ptr), .wr_we(wr_we), .rd_ptr(rd_ptr), .rd_len(rd_len),
        .rd_valid(rd_valid), .rd_done(rd_done), .full(full), .empty(empty),
        .evt_avail(evt_avail), .evt_ovf(evt_ovf), .pg_ovf(pg_ovf)
    );

    // op [15:14]: 0 idle, 1 write, 2 close, 3 abort; [13] expected evt_avail; [12:0] expected wr_ptr
    localparam logic [15:0] VEC [8] = '{
        {2'd1, 1'b0, 13'd1},
        {2'd1, 1'b0, 13'd2},
        {2'd3, 1'b0, 13'd0},
        {2'd1, 1'b0, 13'd1},
        {2'd2, 1'b1, 13'd128},
        {2'd1, 1'b1, 13'd129},
        {2'd2, 1'b1, 13'd256},
        {2'd2, 1'b1, 13'd384}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a falling edge; applies inputs across one rising edge.
    task automatic step(input bit w, input bit c, input bit a, input bit rw, input bit rr);
        wr_word = w; wr_close = c; wr_abort = a; rd_word = rw; rd_release = rr;
        #1 last_we = wr_we;
        @(negedge clk);
        wr_word = 0; wr_close = 0; wr_abort = 0; rd_word = 0; rd_release = 0;
    endtask

    initial begin
        #(150000 * 8);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 wr_ptr", int'(wr_ptr), 0);
        chk("R1 empty", int'(empty), 1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 8; i++) begin
            step(VEC[i][15:14] == 2'd1, VEC[i][15:14] == 2'd2, VEC[i][15:14] == 2'd3, 0, 0);
            chk($sformatf("R2/R3/R4/R6 vec%0d wr_ptr", i), int'(wr_ptr), int'(VEC[i][12:0]));
            chk($sformatf("R8 vec%0d evt_avail", i), int'(evt_avail), int'(VEC[i][13]));
            if (i == 0) chk("R2 wr_we", int'(last_we), 1);
        end

        // Read side
        chk("R8 rd_len page0", int'(rd_len), 1);
        chk("R11 rd_valid", int'(rd_valid), 1);
        step(0, 0, 0, 1, 0);
        chk("R9 rd_ptr word", int'(rd_ptr), 1);
        chk("R9 rd_done", int'(rd_done), 1);
        step(0, 0, 0, 1, 0);
        chk("R9 rd_word ignored", int'(rd_ptr), 1);
        step(0, 0, 0, 0, 1);
        chk("R10 release", int'(rd_ptr), 128);
        chk("R11 valid after release", int'(rd_valid), 0);
        step(0, 0, 0, 0, 0);
        chk("R11 valid next page", int'(rd_valid), 1);
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0);
        chk("R11 zero-length done", int'(rd_done), 1);
        chk("R11 zero-length valid", int'(rd_valid), 0);
        chk("R8 zero rd_len", int'(rd_len), 0);
        step(0, 0, 0, 0, 1);
        chk("R10 release page2", int'(rd_ptr), 384);
        chk("R8 empty", int'(empty), 1);
        step(0, 0, 0, 0, 1);
        chk("R10 release when empty", int'(rd_ptr), 384);

        // Ring walk to full
        for (int i = 0; i < 63; i++) begin
            step(0, 1, 0, 0, 0);
            if (i == 60) chk("R4 page wrap 63->0", int'(wr_ptr), 0);
            if (i == 61) chk("R5 not yet full", int'(full), 0);
        end
        chk("R5 full", int'(full), 1);
        chk("R5 evt_ovf clear", int'(evt_ovf), 0);
        step(1, 0, 0, 0, 0);
        chk("R3 write while full", int'(wr_ptr), 257);
        step(0, 1, 0, 0, 0);
        chk("R5 rejected close ptr", int'(wr_ptr), 256);
        chk("R5 evt_ovf", int'(evt_ovf), 1);
        step(1, 0, 0, 0, 0);
        step(1, 1, 1, 0, 0);
        chk("R6 abort priority ptr", int'(wr_ptr), 256);
        chk("R6 abort blocks write", int'(last_we), 0);

        // Saturation
        for (int i = 0; i < 128; i++) begin
            step(1, 0, 0, 0, 0);
            if (i == 127) chk("R7 128th write accepted", int'(last_we), 1);
        end
        chk("R7 word at 127", int'(wr_ptr), 383);
        chk("R7 pg_ovf clear", int'(pg_ovf), 0);
        step(1, 0, 0, 0, 0);
        chk("R7 extra write blocked", int'(last_we), 0);
        chk("R7 word held", int'(wr_ptr), 383);
        chk("R7 pg_ovf set", int'(pg_ovf), 1);

        // Reset mid-run
        rst_n = 1'b0;
        #2;
        chk("R1 wr_ptr", int'(wr_ptr), 0);
        chk("R1 rd_ptr", int'(rd_ptr), 0);
        chk("R1 full", int'(full), 0);
        chk("R1 evt_ovf", int'(evt_ovf), 0);
        chk("R1 pg_ovf", int'(pg_ovf), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule